// File: doc/BRIEF.md
# Fusing Atomic Operation Buffer

This block sits between a compute core's issue logic and the memory path. It takes reduction-style atomic requests (address, operand, opcode) and keeps them locally instead of sending them on. A request whose address and opcode match a live entry is folded into that entry's operand, so repeated updates to one location cost one slot. A request that matches nothing takes the next free slot. When no slot is left, the request is refused and a sticky full flag tells the issue logic to stop sending.

On a flush command the block walks all slot indices once. It starts at an index given with the command and wraps around modulo the depth. Each live entry goes out on a valid/ready record stream. Because the fill order, the fold order and the drain order depend only on the request sequence and the start index, the final memory updates are reproducible from run to run. Each output record carries a flag that says whether it lies in the same memory sector as the record sent just before it in the same flush, so a downstream coalescer can merge them. Once the walk completes, every entry is cleared and the full flag drops.

Top module: `fab_buffer`

## Requirements
- R1: After reset the buffer holds no entries: `nempty_o`=0, `full_o`=0, `out_valid_o`=0, `flush_busy_o`=0, and `req_ready_o`=1.
- R2: An accepted request whose (address, opcode) pair matches no valid entry is written into the lowest-numbered free slot. Slots therefore fill in acceptance order starting at index 0.
- R3: An accepted request that matches a valid entry on both address and opcode updates only that entry's operand. No slot is allocated. The opcode encodings (`req_op_i`) are 0 = add modulo 2^32, 1 = unsigned minimum, 2 = unsigned maximum and 3 = bitwise xor.
- R4: A request with the same address as a valid entry but a different opcode gets its own slot. At most one entry ever matches a request.
- R5: A request that matches no entry while every slot is valid is refused (`req_ready_o`=0), and `full_o` rises at the next clock edge. While `full_o` is high, every request is refused, including requests that would match an entry.
- R6: `nempty_o` is 1 in the cycle after any request is accepted. It stays 1 until a flush completes.
- R7: A flush visits indices start, start+1, … modulo DEPTH, once each. The start index is `flush_start_i`, sampled with `flush_i`. A record is emitted for each valid entry only, so empty slots are skipped.
- R8: While `out_valid_o`=1 and `out_ready_i`=0, the record is held with address and operand unchanged.
- R9: `req_ready_o` is 0 in any cycle where `flush_i` is high or a flush is in progress (`flush_busy_o`=1).
- R10: `out_same_sect_o` is 1 when the record's address, shifted right by log2(SECTOR_BYTES) (128-byte sectors by default), equals that of the previous record of the same flush. It is 0 on the first record of a flush.
- R11: When the flush walk ends, all entries are invalid: `nempty_o`=0, `full_o`=0 and `flush_busy_o`=0. `req_ready_o` returns to 1 and `out_valid_o` stays 0 outside a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Atomic request present |
| req_ready_o | output | 1 | Request accepted this cycle when high with valid |
| req_addr_i | input | ADDR_W | Target byte address |
| req_opnd_i | input | DATA_W | Operand |
| req_op_i | input | 2 | Opcode: 0 add, 1 umin, 2 umax, 3 xor |
| flush_i | input | 1 | Start a flush (ignored while one runs) |
| flush_start_i | input | log2(DEPTH) | First slot index of the flush walk |
| out_valid_o | output | 1 | Flush record present |
| out_ready_i | input | 1 | Downstream takes the record |
| out_addr_o | output | ADDR_W | Record address |
| out_opnd_o | output | DATA_W | Record reduced operand |
| out_op_o | output | 2 | Record opcode |
| out_same_sect_o | output | 1 | Record shares a sector with the previous record |
| full_o | output | 1 | Sticky full flag, cleared by flush completion |
| nempty_o | output | 1 | At least one valid entry |
| flush_busy_o | output | 1 | Flush walk in progress |

## Verification
The hardest condition to reach is a refused request that would have matched a live entry. Getting there needs every slot filled with distinct address/opcode pairs, then one extra unmatched request to set the sticky full flag, and only then a matching request. The bench uses a depth of 8 so it can fill the buffer with distinct addresses, force the overflow, and then offer a hit. Output backpressure is held low during a flush, and a request is driven in the same window, to show that records are held stable and requests are refused. A walk started mid-buffer shows the skipping of empty slots and the wrap to index 0.

// File: rtl/fab_pkg.sv
package fab_pkg;
  typedef enum logic [1:0] {
    FAB_ADD  = 2'd0,
    FAB_UMIN = 2'd1,
    FAB_UMAX = 2'd2,
    FAB_XOR  = 2'd3
  } fab_op_e;
endpackage

// File: rtl/fab_match.sv
module fab_match #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 40,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]             vld_i,
  input  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr_i,
  input  logic [DEPTH-1:0][1:0]        ent_op_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [1:0]                   op_i,
  output logic [DEPTH-1:0]             hit_vec_o,
  output logic                         hit_o,
  output logic [IDX_W-1:0]             hit_idx_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_vec_o[g] = vld_i[g] && (ent_addr_i[g] == addr_i) && (ent_op_i[g] == op_i);
  end

  assign hit_o = |hit_vec_o;

  always_comb begin
    hit_idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit_vec_o[i]) hit_idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/fab_alu.sv
module fab_alu
  import fab_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  output logic [DATA_W-1:0] res_o
);
  always_comb begin
    unique case (fab_op_e'(op_i))
      FAB_ADD:  res_o = acc_i + opnd_i;
      FAB_UMIN: res_o = (opnd_i < acc_i) ? opnd_i : acc_i;
      FAB_UMAX: res_o = (opnd_i > acc_i) ? opnd_i : acc_i;
      FAB_XOR:  res_o = acc_i ^ opnd_i;
      default:  res_o = acc_i;
    endcase
  end
endmodule

// File: rtl/fab_drain.sv
module fab_drain #(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [IDX_W-1:0] start_i,
  input  logic [DEPTH-1:0] vld_i,
  input  logic             out_ready_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             emit_o,
  output logic             done_o
);
  logic             busy_q;
  logic [IDX_W-1:0] ptr_q;
  logic [CNT_W-1:0] step_q;
  logic             adv;

  assign emit_o = busy_q && vld_i[ptr_q];
  // empty slots cost one cycle each, valid ones wait for the sink
  assign adv    = busy_q && (!vld_i[ptr_q] || out_ready_i);
  assign done_o = adv && (step_q == CNT_W'(DEPTH - 1));
  assign busy_o = busy_q;
  assign idx_o  = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
      step_q <= '0;
    end else if (!busy_q) begin
      if (go_i) begin
        busy_q <= 1'b1;
        ptr_q  <= start_i;
        step_q <= '0;
      end
    end else if (adv) begin
      ptr_q  <= ptr_q + 1'b1;
      step_q <= step_q + 1'b1;
      if (done_o) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/fab_buffer.sv
module fab_buffer
  import fab_pkg::*;
#(
  parameter int DEPTH        = 64,
  parameter int ADDR_W       = 40,
  parameter int DATA_W       = 32,
  parameter int SECTOR_BYTES = 128,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int CNT_W    = IDX_W + 1,
  localparam int SECT_LSB = $clog2(SECTOR_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_opnd_i,
  input  logic [1:0]        req_op_i,
  input  logic              flush_i,
  input  logic [IDX_W-1:0]  flush_start_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [ADDR_W-1:0] out_addr_o,
  output logic [DATA_W-1:0] out_opnd_o,
  output logic [1:0]        out_op_o,
  output logic              out_same_sect_o,
  output logic              full_o,
  output logic              nempty_o,
  output logic              flush_busy_o
);
  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr_q;
  logic [DEPTH-1:0][DATA_W-1:0] ent_opnd_q;
  logic [DEPTH-1:0][1:0]        ent_op_q;
  logic [DEPTH-1:0]             ent_vld_q;
  logic [CNT_W-1:0]             cnt_q;
  logic                         full_q;
  logic [ADDR_W-SECT_LSB-1:0]   prev_sect_q;
  logic                         seen_q;

  logic [DEPTH-1:0] hit_vec;
  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  logic [DATA_W-1:0] fused;
  logic             free_any, busy, emit, done, go, req_fire, out_fire;
  logic [IDX_W-1:0] drn_idx, alloc_idx;
  logic [ADDR_W-SECT_LSB-1:0] cur_sect;

  fab_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_match (
    .vld_i     (ent_vld_q),
    .ent_addr_i(ent_addr_q),
    .ent_op_i  (ent_op_q),
    .addr_i    (req_addr_i),
    .op_i      (req_op_i),
    .hit_vec_o (hit_vec),
    .hit_o     (hit),
    .hit_idx_o (hit_idx)
  );

  fab_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i  (req_op_i),
    .acc_i (ent_opnd_q[hit_idx]),
    .opnd_i(req_opnd_i),
    .res_o (fused)
  );

  assign go = flush_i && !busy;

  fab_drain #(.DEPTH(DEPTH)) u_drain (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (go),
    .start_i    (flush_start_i),
    .vld_i      (ent_vld_q),
    .out_ready_i(out_ready_i),
    .busy_o     (busy),
    .idx_o      (drn_idx),
    .emit_o     (emit),
    .done_o     (done)
  );

  // slots are only freed all at once, so valid entries stay contiguous from 0
  assign free_any  = cnt_q < CNT_W'(DEPTH);
  assign alloc_idx = cnt_q[IDX_W-1:0];
  assign req_ready_o = !busy && !flush_i && !full_q && (hit || free_any);
  assign req_fire    = req_valid_i && req_ready_o;

  assign out_valid_o = emit;
  assign out_addr_o  = ent_addr_q[drn_idx];
  assign out_opnd_o  = ent_opnd_q[drn_idx];
  assign out_op_o    = ent_op_q[drn_idx];
  assign cur_sect    = out_addr_o[ADDR_W-1:SECT_LSB];
  assign out_same_sect_o = emit && seen_q && (cur_sect == prev_sect_q);
  assign out_fire    = emit && out_ready_i;

  assign full_o       = full_q;
  assign nempty_o     = cnt_q != '0;
  assign flush_busy_o = busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_addr_q <= '0;
      ent_opnd_q <= '0;
      ent_op_q   <= '0;
      ent_vld_q  <= '0;
      cnt_q      <= '0;
      full_q     <= 1'b0;
    end else if (done) begin
      ent_vld_q <= '0;
      cnt_q     <= '0;
      full_q    <= 1'b0;
    end else begin
      if (req_valid_i && !busy && !flush_i && !hit && !free_any) full_q <= 1'b1;
      if (req_fire) begin
        if (hit) begin
          ent_opnd_q[hit_idx] <= fused;
        end else begin
          ent_addr_q[alloc_idx] <= req_addr_i;
          ent_opnd_q[alloc_idx] <= req_opnd_i;
          ent_op_q[alloc_idx]   <= req_op_i;
          ent_vld_q[alloc_idx]  <= 1'b1;
          cnt_q                 <= cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_sect_q <= '0;
      seen_q      <= 1'b0;
    end else if (go) begin
      seen_q <= 1'b0;
    end else if (out_fire) begin
      prev_sect_q <= cur_sect;
      seen_q      <= 1'b1;
    end
  end
endmodule

// File: rtl/fab_buffer_chk.sv
module fab_buffer_chk #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 40,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              flush_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [ADDR_W-1:0] out_addr_o,
  input logic [DATA_W-1:0] out_opnd_o,
  input logic              full_o,
  input logic              nempty_o,
  input logic              flush_busy_o,
  input logic [DEPTH-1:0]  hit_vec_i
);
  // R5
  full_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !req_ready_o);
  // R9
  flush_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i || flush_busy_o) |-> !req_ready_o);
  // R8
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_addr_o) && $stable(out_opnd_o)));
  // R6
  nempty_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> nempty_o);
  // R4
  single_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec_i));
  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_busy_o |-> !out_valid_o);
endmodule

bind fab_buffer fab_buffer_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .flush_i     (flush_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_addr_o  (out_addr_o),
  .out_opnd_o  (out_opnd_o),
  .full_o      (full_o),
  .nempty_o    (nempty_o),
  .flush_busy_o(flush_busy_o),
  .hit_vec_i   (hit_vec)
);

// File: tb/fab_buffer_tb_top.sv
module fab_buffer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int AW = 40;
  localparam int DW = 32;
  localparam int NV = 8;
  localparam int NE = 4;

  // request table: merges on same addr+op, split on same addr different op
  localparam logic [AW-1:0] V_ADDR [NV] = '{40'h100, 40'h100, 40'h100, 40'h104,
                                            40'h100, 40'h104, 40'h200, 40'h200};
  localparam logic [DW-1:0] V_OPND [NV] = '{32'd5, 32'd7, 32'd9, 32'd3,
                                            32'd4, 32'd10, 32'hF0, 32'h3C};
  localparam logic [1:0]    V_OP   [NV] = '{2'd0, 2'd0, 2'd1, 2'd2, 2'd1, 2'd2, 2'd3, 2'd3};
  // expected flush records from start index 0
  localparam logic [AW-1:0] E_ADDR [NE] = '{40'h100, 40'h100, 40'h104, 40'h200};
  localparam logic [DW-1:0] E_OPND [NE] = '{32'd12, 32'd4, 32'd10, 32'hCC};
  localparam logic [1:0]    E_OP   [NE] = '{2'd0, 2'd1, 2'd2, 2'd3};
  localparam logic          E_SAME [NE] = '{1'b0, 1'b1, 1'b1, 1'b0};

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_ready_o;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_opnd_i = '0;
  logic [1:0] req_op_i = '0;
  logic flush_i = 1'b0;
  logic [2:0] flush_start_i = '0;
  logic out_valid_o, out_ready_i = 1'b1;
  logic [AW-1:0] out_addr_o;
  logic [DW-1:0] out_opnd_o;
  logic [1:0] out_op_o;
  logic out_same_sect_o, full_o, nempty_o, flush_busy_o;

  int n_chk = 0, n_bad = 0, n_got = 0;
  logic [AW-1:0] g_addr [16];
  logic [DW-1:0] g_opnd [16];
  logic [1:0]    g_op   [16];
  logic          g_same [16];
  bit acc;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fab_buffer #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW), .SECTOR_BYTES(128)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] op, output bit ok);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = a; req_opnd_i = d; req_op_i = op;
    #1 ok = req_ready_o;
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic start_flush(input logic [2:0] s);
    @(negedge clk_i);
    flush_i = 1'b1; flush_start_i = s;
    @(negedge clk_i);
    flush_i = 1'b0;
  endtask

  task automatic collect();
    n_got = 0;
    while (flush_busy_o) begin
      #1;
      if (out_valid_o && out_ready_i && n_got < 16) begin
        g_addr[n_got] = out_addr_o; g_opnd[n_got] = out_opnd_o;
        g_op[n_got] = out_op_o; g_same[n_got] = out_same_sect_o;
        n_got++;
      end
      @(negedge clk_i);
    end
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(3*CLK_PERIOD) rst_ni = 1'b1;
    @(negedge clk_i); #1;
    // R1 reset state
    chk(!nempty_o && !full_o && !out_valid_o && !flush_busy_o, "R1 idle flags", {nempty_o, full_o, out_valid_o, flush_busy_o}, 0);
    chk(req_ready_o, "R1 ready", req_ready_o, 1);

    // table walk: R2 R3 R4
    for (int i = 0; i < NV; i++) begin
      send(V_ADDR[i], V_OPND[i], V_OP[i], acc);
      chk(acc, "R2 accept", acc, 1);
    end
    #1;
    chk(nempty_o && !full_o, "R6 nempty after fill", {nempty_o, full_o}, 2'b10);
    start_flush(3'd0);
    collect();
    chk(n_got == NE, "R3 merged record count", n_got, NE);
    for (int i = 0; i < NE; i++) begin
      chk(g_addr[i] == E_ADDR[i], "R2 record addr", g_addr[i], E_ADDR[i]);
      chk(g_opnd[i] == E_OPND[i], "R3 fused operand", g_opnd[i], E_OPND[i]);
      chk(g_op[i] == E_OP[i], "R4 record opcode", g_op[i], E_OP[i]);
      chk(g_same[i] == E_SAME[i], "R10 sector tag", g_same[i], E_SAME[i]);
    end
    #1;
    chk(!nempty_o && !flush_busy_o, "R11 cleared after flush", {nempty_o, flush_busy_o}, 0);

    // wrap-around walk from index 2, skipping empty slots (R7), flush+request same cycle (R9)
    send(40'h1000, 32'd1, 2'd0, acc);
    send(40'h2000, 32'd2, 2'd0, acc);
    send(40'h3000, 32'd3, 2'd0, acc);
    @(negedge clk_i);
    flush_i = 1'b1; flush_start_i = 3'd2;
    req_valid_i = 1'b1; req_addr_i = 40'h1000; req_op_i = 2'd0; req_opnd_i = 32'd9;
    #1 chk(!req_ready_o, "R9 blocked with flush_i", req_ready_o, 0);
    @(negedge clk_i);
    flush_i = 1'b0; req_valid_i = 1'b0;
    collect();
    chk(n_got == 3, "R7 wrap count", n_got, 3);
    chk(g_addr[0] == 40'h3000 && g_addr[1] == 40'h1000 && g_addr[2] == 40'h2000,
        "R7 wrap order", {g_addr[0][15:12], g_addr[1][15:12], g_addr[2][15:12]}, 12'h312);
    chk(g_opnd[1] == 32'd1, "R9 blocked request had no effect", g_opnd[1], 1);
    chk(g_same[0] == 1'b0, "R10 first record untagged", g_same[0], 0);

    // backpressure hold (R8), request during flush (R9)
    send(40'h4000, 32'd7, 2'd3, acc);
    send(40'h5000, 32'd8, 2'd3, acc);
    out_ready_i = 1'b0;
    start_flush(3'd1);
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(out_valid_o && out_addr_o == 40'h5000 && out_opnd_o == 32'd8, "R8 hold record", out_addr_o, 40'h5000);
      @(negedge clk_i);
    end
    req_valid_i = 1'b1; req_addr_i = 40'h4000; req_op_i = 2'd3;
    #1 chk(!req_ready_o, "R9 blocked during flush", req_ready_o, 0);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    out_ready_i = 1'b1;
    collect();
    chk(n_got == 2 && g_addr[1] == 40'h4000, "R8 drain after release", n_got, 2);

    // full handling (R5) and recovery (R11)
    for (int k = 1; k <= DEPTH; k++) begin
      send(AW'(k) << 12, DW'(k), 2'd0, acc);
      chk(acc, "R2 fill slot", acc, 1);
    end
    send(40'h9000, 32'd1, 2'd0, acc);
    chk(!acc, "R5 refuse when no room", acc, 0);
    #1 chk(full_o, "R5 full raised", full_o, 1);
    send(40'h1000, 32'd5, 2'd0, acc);
    chk(!acc, "R5 hit refused while full", acc, 0);
    start_flush(3'd0);
    collect();
    chk(n_got == DEPTH, "R5 all entries drained", n_got, DEPTH);
    chk(g_addr[0] == 40'h1000 && g_opnd[0] == 32'd1, "R5 refused hit had no effect", g_opnd[0], 1);
    #1;
    chk(!full_o && !nempty_o && req_ready_o, "R11 full cleared", {full_o, nempty_o, req_ready_o}, 3'b001);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule